// File: doc/BRIEF.md
# Capture/Compare Event Flag Register

This block holds one sticky status flag per timer channel. A channel's event strobe, from an input capture or an output compare, sets its flag. Software removes flags in one of two ways. In the normal scheme it writes ones to the flag register, and that write only takes effect while the timer enable or the pulse-accumulator enable is on. In the fast-clear scheme, a read of a channel's capture register or a write to its compare register clears that channel's flag as a side effect.

A parameter mask lists the channels that exist. Flags of absent channels stay zero whatever the stimulus. The block also produces a single interrupt request. The request is the OR of every flag gated by that channel's interrupt-enable bit. The capture and compare datapaths are outside the block. Only their access strobes and the channel index come in.

Top module: `evt_flag_reg`

## Requirements
- R1: An event strobe on a present channel sets that channel's flag, which becomes visible after the next rising clock edge.
- R2: A flag-register write with data bit i at one clears flag i. A data bit at zero leaves its flag unchanged.
- R3: A flag-register write clears nothing unless the timer enable or the pulse-accumulator enable is one.
- R4: With the fast-clear mode bit at one, a capture-register read strobe or a compare-register write strobe clears the flag of the channel selected by the 3-bit index. With the mode bit at zero, these strobes clear nothing.
- R5: Flags of channels whose bit in the presence mask (parameter CH_PRESENT, default 8'h7F, bit i for channel i) is zero always read zero. Events and writes do not change them.
- R6: During and after reset, all flags are zero and the interrupt request is low. The flags can be read in every cycle.
- R7: When an event and any clear request hit the same flag in the same cycle, the flag ends up set.
- R8: The interrupt request is high exactly when some flag is set and its interrupt-enable bit is one.
- R9: A fast-clear access clears only the indexed channel's flag and leaves the other flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 8 | Per-channel capture/compare event strobes |
| flag_wr_i | input | 1 | Write strobe for the flag register |
| flag_wdata_i | input | 8 | Write data, where a one requests a clear |
| tmr_en_i | input | 1 | Timer enable |
| pacc_en_i | input | 1 | Pulse-accumulator enable |
| fast_clr_i | input | 1 | Fast-clear mode bit |
| cap_rd_i | input | 1 | Capture-register read strobe |
| cmp_wr_i | input | 1 | Compare-register write strobe |
| ch_idx_i | input | 3 | Channel index of the capture/compare access |
| irq_en_i | input | 8 | Per-channel interrupt enables |
| flags_o | output | 8 | Flag register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
An event and a clear request can land on the same flag in one cycle. The bench provokes this with both clear routes. In one cycle it raises the event strobe together with an enabled write-one. In another it raises the event together with a fast-clear capture read of the same channel. The flag must read set afterwards, and the clears aimed at other channels in those cycles must still take effect. A cycle that combines a write-one clear with a fast-clear access on a different channel checks that both clears apply together.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  localparam int unsigned CH_NUM = 8;
  localparam int unsigned IDX_W  = $clog2(CH_NUM);

  typedef logic [CH_NUM-1:0] ch_vec_t;

  function automatic ch_vec_t idx_to_vec(input logic [IDX_W-1:0] idx);
    ch_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/evt_clr_dec.sv
module evt_clr_dec
  import evt_flag_pkg::*;
(
  input  logic             flag_wr_i,
  input  ch_vec_t          flag_wdata_i,
  input  logic             tmr_en_i,
  input  logic             pacc_en_i,
  input  logic             fast_clr_i,
  input  logic             cap_rd_i,
  input  logic             cmp_wr_i,
  input  logic [IDX_W-1:0] ch_idx_i,
  output ch_vec_t          clr_o
);
  ch_vec_t wr_clr;
  ch_vec_t acc_clr;

  always_comb begin
    wr_clr  = '0;
    acc_clr = '0;
    if (flag_wr_i && (tmr_en_i || pacc_en_i)) wr_clr = flag_wdata_i;
    if (fast_clr_i && (cap_rd_i || cmp_wr_i)) acc_clr = idx_to_vec(ch_idx_i);
    clr_o = wr_clr | acc_clr;
  end
endmodule

// File: rtl/evt_flag_cell.sv
module evt_flag_cell #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (PRESENT) begin : g_live
      logic flag_q;
      logic flag_d;
      logic flag_ce;

      always_comb begin
        flag_ce = evt_i | clr_i;
        flag_d  = evt_i | (flag_q & ~clr_i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_ce) flag_q <= flag_d;
      end

      assign flag_o = flag_q;
    end else begin : g_absent
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ evt_i ^ clr_i;
      assign flag_o    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/evt_flag_reg.sv
module evt_flag_reg
  import evt_flag_pkg::*;
#(
  parameter logic [7:0] CH_PRESENT = 8'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_i,
  input  logic       flag_wr_i,
  input  logic [7:0] flag_wdata_i,
  input  logic       tmr_en_i,
  input  logic       pacc_en_i,
  input  logic       fast_clr_i,
  input  logic       cap_rd_i,
  input  logic       cmp_wr_i,
  input  logic [2:0] ch_idx_i,
  input  logic [7:0] irq_en_i,
  output logic [7:0] flags_o,
  output logic       irq_o
);
  logic    rst_sn;
  ch_vec_t clr_vec;
  ch_vec_t flag_vec;

  evt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  evt_clr_dec u_dec (
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .tmr_en_i     (tmr_en_i),
    .pacc_en_i    (pacc_en_i),
    .fast_clr_i   (fast_clr_i),
    .cap_rd_i     (cap_rd_i),
    .cmp_wr_i     (cmp_wr_i),
    .ch_idx_i     (ch_idx_i),
    .clr_o        (clr_vec)
  );

  for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
    evt_flag_cell #(.PRESENT(CH_PRESENT[i])) u_cell (
      .clk    (clk),
      .rst_n  (rst_sn),
      .evt_i  (evt_i[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (flag_vec[i])
    );
  end

  always_comb begin
    flags_o = flag_vec;
    irq_o   = |(flag_vec & irq_en_i);
  end
endmodule

// File: rtl/evt_flag_reg_chk.sv
module evt_flag_reg_chk #(
  parameter logic [7:0] CH_PRESENT = 8'h7F
) (
  input logic       clk,
  input logic       rst_sn,
  input logic [7:0] evt_i,
  input logic       flag_wr_i,
  input logic       tmr_en_i,
  input logic       pacc_en_i,
  input logic       fast_clr_i,
  input logic       cap_rd_i,
  input logic       cmp_wr_i,
  input logic [2:0] ch_idx_i,
  input logic [7:0] irq_en_i,
  input logic [7:0] flags_o,
  input logic       irq_o
);
  logic acc_clr;
  logic wr_clr;
  assign acc_clr = fast_clr_i && (cap_rd_i || cmp_wr_i);
  assign wr_clr  = flag_wr_i && (tmr_en_i || pacc_en_i);

  // R1 and R7: an event always leaves its flag set
  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    ((evt_i & CH_PRESENT) != 8'h00) |=>
      ((flags_o & $past(evt_i & CH_PRESENT)) == $past(evt_i & CH_PRESENT)));

  // R5: absent channels read zero
  assert_absent_zero_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    ((flags_o & ~CH_PRESENT) == 8'h00));

  // R3: without an honoured clear no flag falls
  assert_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_clr && !acc_clr) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R9: a lone fast-clear access touches only the indexed flag
  assert_one_channel_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_clr && !flag_wr_i && (evt_i == 8'h00)) |=>
      (flags_o == ($past(flags_o) & ~(8'h01 << $past(ch_idx_i)))));

  // R8: no request without an enabled flag
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    ((flags_o & irq_en_i) == 8'h00) |-> !irq_o);
endmodule

bind evt_flag_reg evt_flag_reg_chk #(.CH_PRESENT(CH_PRESENT)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .evt_i      (evt_i),
  .flag_wr_i  (flag_wr_i),
  .tmr_en_i   (tmr_en_i),
  .pacc_en_i  (pacc_en_i),
  .fast_clr_i (fast_clr_i),
  .cap_rd_i   (cap_rd_i),
  .cmp_wr_i   (cmp_wr_i),
  .ch_idx_i   (ch_idx_i),
  .irq_en_i   (irq_en_i),
  .flags_o    (flags_o),
  .irq_o      (irq_o)
);

// File: tb/evt_flag_reg_tb.sv
module evt_flag_reg_tb;
  localparam logic [7:0] PRES = 8'h7F;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_i;
  logic       flag_wr_i;
  logic [7:0] flag_wdata_i;
  logic       tmr_en_i;
  logic       pacc_en_i;
  logic       fast_clr_i;
  logic       cap_rd_i;
  logic       cmp_wr_i;
  logic [2:0] ch_idx_i;
  logic [7:0] irq_en_i;
  logic [7:0] flags_o;
  logic       irq_o;

  always #10 clk = ~clk;

  evt_flag_reg #(.CH_PRESENT(PRES)) u_dut (.*);

  typedef struct {
    logic [7:0] flags;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  task automatic step(input logic [7:0] evt, input logic wr, input logic [7:0] wd,
                      input logic ten, input logic pen, input logic ffc,
                      input logic rd, input logic cw, input logic [2:0] idx,
                      input logic [7:0] ien, input string tag);
    logic [7:0] clr;
    exp_t e;
    @(negedge clk);
    evt_i = evt; flag_wr_i = wr; flag_wdata_i = wd; tmr_en_i = ten;
    pacc_en_i = pen; fast_clr_i = ffc; cap_rd_i = rd; cmp_wr_i = cw;
    ch_idx_i = idx; irq_en_i = ien;
    clr = 8'h00;
    if (wr && (ten || pen)) clr = clr | wd;
    if (ffc && (rd || cw)) clr = clr | (8'h01 << idx);
    model = ((model & ~clr) | evt) & PRES;
    e.flags = model;
    e.irq   = |(model & ien);
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (flags_o !== e.flags || irq_o !== e.irq) begin
          fails++;
          $display("FAIL %s flags=%h irq=%b expected flags=%h irq=%b",
                   e.tag, flags_o, irq_o, e.flags, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    model = 8'h00;
    rst_n = 1'b0;
    evt_i = 8'h00; flag_wr_i = 1'b0; flag_wdata_i = 8'h00; tmr_en_i = 1'b0;
    pacc_en_i = 1'b0; fast_clr_i = 1'b0; cap_rd_i = 1'b0; cmp_wr_i = 1'b0;
    ch_idx_i = 3'd0; irq_en_i = 8'hFF;
    repeat (3) @(negedge clk);
    checks++;
    if (flags_o !== 8'h00 || irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R6 in reset flags=%h irq=%b expected flags=00 irq=0", flags_o, irq_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 8'hFF, "R6 after reset");
    step(8'h05, 0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, "R1 set ch0 ch2, R8 masked");
    step(8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h04, "R8 enabled ch2");
    step(8'h00, 1, 8'h05, 0, 0, 0, 0, 0, 0, 8'h00, "R3 write without enable");
    step(8'h00, 1, 8'h00, 1, 0, 0, 0, 0, 0, 8'h00, "R2 write zero keeps");
    step(8'h00, 1, 8'h01, 1, 0, 0, 0, 0, 0, 8'h00, "R2 clear ch0 via timer enable");
    step(8'h00, 1, 8'h04, 0, 1, 0, 0, 0, 0, 8'h01, "R3 clear ch2 via accumulator enable");
    step(8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h80, "R5 ch7 event ignored, R8 absent enable");
    step(8'h00, 1, 8'h80, 1, 0, 0, 0, 0, 0, 8'h00, "R5 write to ch7");
    step(8'h00, 0, 8'h00, 0, 0, 0, 1, 0, 3'd2, 8'h00, "R4 capture read without mode");
    step(8'h00, 0, 8'h00, 0, 0, 1, 1, 0, 3'd2, 8'h00, "R4 R9 capture read clears ch2 only");
    step(8'h00, 0, 8'h00, 0, 0, 1, 0, 1, 3'd4, 8'h00, "R4 R9 compare write clears ch4 only");
    step(8'h00, 0, 8'h00, 0, 0, 1, 0, 1, 3'd7, 8'h00, "R5 R9 fast clear on absent ch7");
    step(8'h02, 1, 8'h0A, 1, 0, 0, 0, 0, 0, 8'h00, "R7 event beats write clear on ch1");
    step(8'h20, 0, 8'h00, 0, 0, 1, 1, 0, 3'd5, 8'h20, "R7 event beats fast clear on ch5");
    step(8'h00, 1, 8'h01, 0, 1, 1, 0, 1, 3'd6, 8'h41, "R2 R4 write and fast clear together");
    step(8'h00, 1, 8'hFF, 1, 1, 0, 0, 0, 0, 8'hFF, "R2 clear all, R8 low");
    step(8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 8'hFF, "R6 readable idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule